// File: doc/BRIEF.md
# Ordered Store Buffer with Read Bypass

This block sits between a load/store pipeline and a single memory port. Stores arrive speculatively and wait in a small circular queue. The pipeline later either commits them, oldest first, or flushes the ones it has not yet committed. Only committed stores at the head of the queue are written to memory. They leave strictly in the order they arrived, at most one per cycle, so writes never reorder among themselves.

Reads share the same memory port. Reads are the frequent traffic and data writes are comparatively rare, so a read that hits in the cache is given the port ahead of any queued write. The one exception is a read whose word address matches a write still held in the buffer. That read is held back until every such write has left the buffer. A read that misses the cache is never promoted and waits until the buffer is empty. The grant decision depends only on the read's hit flag and the address comparison. No external write-completion signal takes part in it.

The requester keeps a read request asserted until it sees the grant, and keeps a store asserted while the full flag is high. The memory port has no back-pressure: the port accepts whatever is presented, one operation per cycle.

Top module: `store_buffer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wbEmpty` is 1, `enqFull` is 0 and `memValid` is 0.
- R2: A store presented on `enqValid` is accepted when fewer than DEPTH (8) entries are valid. With DEPTH entries valid, `enqFull` is 1 and the store is refused: no entry is added, so the later drain sequence contains no trace of it.
- R3: Committed stores appear on the memory port (`memValid`=1, `memWrite`=1) in the order they were accepted, each with its own address, data and byte enables.
- R4: An uncommitted entry never drains. Each `commit` pulse marks the oldest uncommitted entry as committed. A pulse with no uncommitted entry present, or in the same cycle as `flush`, has no effect.
- R5: `flush` removes every uncommitted entry in one cycle, including a store accepted in that same cycle, and leaves committed entries in place and in order.
- R6: A read with `rdHit`=1 whose word address matches no valid entry is granted in the same cycle. `rdGrant`=1, `memValid`=1, `memWrite`=0 and `memAddr`=`rdAddr`, and no write drains in that cycle.
- R7: A read with `rdHit`=1 whose word address matches any valid entry, committed or not, is not granted. It is granted in the cycle after the last matching entry has drained or been flushed.
- R8: A read with `rdHit`=0 is granted only in a cycle in which no valid entry remains.
- R9: When no read is granted and the head entry is committed, that entry drains in this cycle. At most one write drains per cycle.
- R10: `wbEmpty` is 1 exactly when no entry is valid.
- R11: Address matching compares the full 32-bit word address only. Byte enables, data and commit state do not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| enqValid | input | 1 | Store request from the pipeline |
| enqAddr | input | 32 | Store word address |
| enqData | input | 32 | Store data |
| enqBe | input | 4 | Store byte enables |
| enqFull | output | 1 | Buffer full; store refused this cycle |
| commit | input | 1 | Commit the oldest uncommitted store |
| flush | input | 1 | Discard all uncommitted stores |
| rdValid | input | 1 | Read request, held until granted |
| rdAddr | input | 32 | Read word address |
| rdHit | input | 1 | Read hits in the cache |
| rdGrant | output | 1 | Read issued on the memory port this cycle |
| memValid | output | 1 | Memory port operation valid |
| memWrite | output | 1 | 1 for a drained write, 0 for a read |
| memAddr | output | 32 | Memory port word address |
| memData | output | 32 | Write data (zero on reads) |
| memBe | output | 4 | Write byte enables (zero on reads) |
| wbEmpty | output | 1 | No valid entry in the buffer |

## Verification
Directed sequences separate the cases one at a time:
- A plain enqueue, commit and drain run shows write ordering.
- Stores left uncommitted, and a cycle that combines flush with commit and enqueue, show speculative handling apart from draining.
- Filling past capacity shows refusal.
- A hit read to an unrelated address while committed writes wait shows overtaking.
- A hit read to a buffered address, including one held only by a speculative entry with different byte enables, shows blocking and release one cycle after the last matching drain.
- A miss read shows waiting for an empty buffer.

A long stretch of mixed random traffic over a few colliding addresses, with reads held until granted, then looks for interactions that the directed runs miss.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic enqWrite;   // write the incoming store at the tail slot
    logic headPop;    // head entry is leaving on the memory port
  } sbStrobe_t;

  // Memory port operation chosen by the arbiter
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_READ  = 2'd1,
    PORT_WRITE = 2'd2
  } portOp_t;

endpackage

// File: rtl/sbuf_datapath.sv
module sbuf_datapath
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEW   = DW / 8,
  parameter int PTRW  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  sbStrobe_t         strobe,
  input  logic [PTRW-1:0]   enqIdx,
  input  logic [PTRW-1:0]   headIdx,
  input  logic [DEPTH-1:0]  validMask,
  input  logic [AW-1:0]     enqAddr,
  input  logic [DW-1:0]     enqData,
  input  logic [BEW-1:0]    enqBe,
  input  logic [AW-1:0]     rdAddr,
  output logic [AW-1:0]     headAddr,
  output logic [DW-1:0]     headData,
  output logic [BEW-1:0]    headBe,
  output logic              matchAny
);

  logic [AW-1:0]    addrQ [DEPTH];
  logic [DW-1:0]    dataQ [DEPTH];
  logic [BEW-1:0]   beQ   [DEPTH];
  logic [DEPTH-1:0] matchVec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (strobe.enqWrite && (enqIdx == PTRW'(i))) begin
        addrQ[i] <= enqAddr;
        dataQ[i] <= enqData;
        beQ[i]   <= enqBe;
      end
    end

    // word-granular compare, only live entries count
    assign matchVec[i] = validMask[i] && (addrQ[i] == rdAddr);
  end

  assign matchAny = |matchVec;
  assign headAddr = addrQ[headIdx];
  assign headData = dataQ[headIdx];
  assign headBe   = beQ[headIdx];

endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTRW  = $clog2(DEPTH),
  parameter int CNTW  = PTRW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enqValid,
  input  logic             commit,
  input  logic             flush,
  input  logic             rdValid,
  input  logic             rdHit,
  input  logic             matchAny,
  output sbStrobe_t        strobe,
  output logic [PTRW-1:0]  enqIdx,
  output logic [PTRW-1:0]  headIdx,
  output logic [DEPTH-1:0] validMask,
  output logic             enqFull,
  output logic             wbEmpty,
  output logic             rdGrant,
  output portOp_t          portOp
);

  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  logic [PTRW-1:0] headQ;
  logic [CNTW-1:0] cntQ;       // valid entries
  logic [CNTW-1:0] commitCntQ; // committed entries, contiguous from head

  logic enqAccept, commitEff, drain;

  // occupancy flags
  assign wbEmpty = (cntQ == '0);
  assign enqFull = (cntQ == FULL_CNT);

  // live-entry mask, relative to the head pointer
  for (genvar i = 0; i < DEPTH; i++) begin : g_valid
    logic [PTRW-1:0] offs;
    assign offs         = PTRW'(i) - headQ;
    assign validMask[i] = ({1'b0, offs} < cntQ);
  end

  assign headIdx = headQ;
  assign enqIdx  = headQ + cntQ[PTRW-1:0];

  // port arbitration: hit reads win unless blocked, miss reads need empty
  always_comb begin
    rdGrant = rdValid && (rdHit ? !matchAny : wbEmpty);
    drain   = !rdGrant && (commitCntQ != '0);
    if (rdGrant)    portOp = PORT_READ;
    else if (drain) portOp = PORT_WRITE;
    else            portOp = PORT_IDLE;
  end

  assign enqAccept       = enqValid && !enqFull;
  assign commitEff       = commit && !flush && (commitCntQ < cntQ);
  assign strobe.enqWrite = enqAccept && !flush;
  assign strobe.headPop  = drain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ      <= '0;
      cntQ       <= '0;
      commitCntQ <= '0;
    end else begin
      headQ      <= headQ + PTRW'(drain);
      commitCntQ <= commitCntQ - CNTW'(drain) + CNTW'(commitEff);
      if (flush) cntQ <= commitCntQ - CNTW'(drain);
      else       cntQ <= cntQ - CNTW'(drain) + CNTW'(strobe.enqWrite);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= FULL_CNT) else $error("occupancy over depth");                  // R2

  AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    enqFull |=> cntQ <= FULL_CNT) else $error("grew past full");             // R2

  AST_COMMIT_WITHIN: assert property (@(posedge clk) disable iff (!rstN)
    commitCntQ <= cntQ) else $error("committed beyond valid");              // R4

  AST_FLUSH_KEEPS_COMMITTED: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (cntQ == commitCntQ)) else $error("flush left speculative");  // R5

  AST_COMMIT_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!commit && !portOp[1]) |=> $stable(commitCntQ)) else $error("commit moved"); // R4

endmodule

// File: rtl/store_buffer.sv
module store_buffer
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEW   = DW / 8,
  parameter int PTRW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           enqValid,
  input  logic [AW-1:0]  enqAddr,
  input  logic [DW-1:0]  enqData,
  input  logic [BEW-1:0] enqBe,
  output logic           enqFull,
  input  logic           commit,
  input  logic           flush,
  input  logic           rdValid,
  input  logic [AW-1:0]  rdAddr,
  input  logic           rdHit,
  output logic           rdGrant,
  output logic           memValid,
  output logic           memWrite,
  output logic [AW-1:0]  memAddr,
  output logic [DW-1:0]  memData,
  output logic [BEW-1:0] memBe,
  output logic           wbEmpty
);

  sbStrobe_t        strobe;
  portOp_t          portOp;
  logic [PTRW-1:0]  enqIdx, headIdx;
  logic [DEPTH-1:0] validMask;
  logic [AW-1:0]    headAddr;
  logic [DW-1:0]    headData;
  logic [BEW-1:0]   headBe;
  logic             matchAny;

  sbuf_ctrl #(.DEPTH(DEPTH), .PTRW(PTRW)) u_ctrl (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .commit(commit),
    .flush(flush), .rdValid(rdValid), .rdHit(rdHit), .matchAny(matchAny),
    .strobe(strobe), .enqIdx(enqIdx), .headIdx(headIdx),
    .validMask(validMask), .enqFull(enqFull), .wbEmpty(wbEmpty),
    .rdGrant(rdGrant), .portOp(portOp)
  );

  sbuf_datapath #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .BEW(BEW), .PTRW(PTRW)) u_dp (
    .clk(clk), .strobe(strobe), .enqIdx(enqIdx), .headIdx(headIdx),
    .validMask(validMask), .enqAddr(enqAddr), .enqData(enqData),
    .enqBe(enqBe), .rdAddr(rdAddr), .headAddr(headAddr),
    .headData(headData), .headBe(headBe), .matchAny(matchAny)
  );

  always_comb begin
    memValid = (portOp != PORT_IDLE);
    memWrite = (portOp == PORT_WRITE);
    memAddr  = (portOp == PORT_READ) ? rdAddr : headAddr;
    memData  = memWrite ? headData : '0;
    memBe    = memWrite ? headBe   : '0;
  end

  AST_HIT_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memWrite && rdHit) |-> !matchAny) else $error("read passed a match"); // R7

  AST_HIT_READ_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdHit && !matchAny) |-> (memValid && !memWrite)) else $error("bypass lost"); // R6

  AST_MISS_READ_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memWrite && !rdHit) |-> wbEmpty) else $error("miss read promoted"); // R8

  AST_EMPTY_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wbEmpty |-> !(memValid && memWrite)) else $error("write from empty buffer"); // R10

  AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite) |=> $changed(headIdx)) else $error("head not advanced"); // R3

endmodule

// File: tb/store_buffer_test.sv
module store_buffer_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enqValid = 1'b0, commit = 1'b0, flush = 1'b0;
  logic [31:0] enqAddr = '0, enqData = '0, rdAddr = '0;
  logic [3:0]  enqBe = '0;
  logic        rdValid = 1'b0, rdHit = 1'b0;
  logic        enqFull, rdGrant, memValid, memWrite, wbEmpty;
  logic [31:0] memAddr, memData;
  logic [3:0]  memBe;

  always #5 clk = ~clk;

  store_buffer uut (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqAddr(enqAddr),
    .enqData(enqData), .enqBe(enqBe), .enqFull(enqFull), .commit(commit),
    .flush(flush), .rdValid(rdValid), .rdAddr(rdAddr), .rdHit(rdHit),
    .rdGrant(rdGrant), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .memData(memData), .memBe(memBe), .wbEmpty(wbEmpty)
  );

  typedef struct { logic [31:0] a; logic [31:0] d; logic [3:0] b; bit c; } ent_t;
  ent_t  mq[$];
  int    checks = 0, errors = 0, cyc = 0;
  string phase = "R1";
  bit    lastGrant = 0, done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", phase, tag, act, exp);
    end
  endtask

  // inputs are set at the falling edge; compare, then advance the model
  task automatic step();
    bit full, empty, match, grant, drain;
    ent_t e;
    #1;
    full  = (mq.size() == DEPTH);
    empty = (mq.size() == 0);
    match = 0;
    foreach (mq[i]) if (mq[i].a == rdAddr) match = 1;   // R11 word address only
    grant = rdValid && (rdHit ? !match : empty);
    drain = !grant && !empty && mq[0].c;
    lastGrant = grant;
    chk("R2 enqFull", {31'd0, enqFull}, {31'd0, full});
    chk("R10 wbEmpty", {31'd0, wbEmpty}, {31'd0, empty});
    chk(rdHit ? (match ? "R7 rdGrant" : "R6 rdGrant") : "R8 rdGrant",
        {31'd0, rdGrant}, {31'd0, grant});
    chk("R9 memValid", {31'd0, memValid}, {31'd0, grant || drain});
    if (grant || drain) chk("R9 memWrite", {31'd0, memWrite}, {31'd0, drain});
    if (grant) chk("R6 memAddr", memAddr, rdAddr);
    if (drain) begin
      chk("R3 memAddr", memAddr, mq[0].a);
      chk("R3 memData", memData, mq[0].d);
      chk("R3 memBe", {28'd0, memBe}, {28'd0, mq[0].b});
    end
    @(posedge clk);
    if (drain) void'(mq.pop_front());
    if (commit && !flush)
      for (int i = 0; i < mq.size(); i++)
        if (!mq[i].c) begin mq[i].c = 1; break; end
    if (enqValid && !full && !flush) begin
      e.a = enqAddr; e.d = enqData; e.b = enqBe; e.c = 0;
      mq.push_back(e);
    end
    if (flush) while (mq.size() > 0 && !mq[mq.size()-1].c) void'(mq.pop_back());
    @(negedge clk);
  endtask

  task automatic idleIn();
    enqValid = 0; commit = 0; flush = 0; rdValid = 0; rdHit = 0;
  endtask

  task automatic push(logic [31:0] a, logic [31:0] d, logic [3:0] b);
    enqValid = 1; enqAddr = a; enqData = d; enqBe = b;
    step();
    enqValid = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected<=%0d cycles", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    phase = "R1";
    chk("R1 wbEmpty", {31'd0, wbEmpty}, 32'd1);
    chk("R1 enqFull", {31'd0, enqFull}, 32'd0);
    chk("R1 memValid", {31'd0, memValid}, 32'd0);
    rstN = 1;
    step();

    // R3: ordered drain after commit
    phase = "R3";
    push(32'h100, 32'hA0A0_0001, 4'hF);
    push(32'h104, 32'hA0A0_0002, 4'h3);
    push(32'h108, 32'hA0A0_0003, 4'h8);
    commit = 1; run(3); commit = 0;
    run(4);

    // R4: speculative stores stay, commit takes the oldest, spare commit ignored
    phase = "R4";
    push(32'h200, 32'h1111_0000, 4'hF);
    push(32'h204, 32'h2222_0000, 4'hF);
    run(3);
    commit = 1; step(); commit = 0;
    run(3);
    commit = 1; run(2); commit = 0;
    run(3);

    // R5: flush with commit and enqueue in the same cycle
    phase = "R5";
    push(32'h300, 32'h3333_0001, 4'h1);
    push(32'h304, 32'h3333_0002, 4'h2);
    push(32'h308, 32'h3333_0003, 4'h4);
    commit = 1; step(); commit = 0;
    flush = 1; commit = 1; enqValid = 1; enqAddr = 32'h30C; enqData = 32'h3333_0004;
    step();
    flush = 0; commit = 0; enqValid = 0;
    run(4);

    // R2: fill to depth, refuse the ninth and a held store
    phase = "R2";
    for (int i = 0; i < 9; i++) push(32'h400 + 32'(i), 32'hBEEF_0000 + 32'(i), 4'hF);
    enqValid = 1; enqAddr = 32'h4FF; run(3); enqValid = 0;
    commit = 1; run(8); commit = 0;
    run(10);

    // R6: hit read overtakes committed writes
    phase = "R6";
    push(32'h500, 32'h5555_0001, 4'hF);
    push(32'h504, 32'h5555_0002, 4'hF);
    commit = 1; step(); commit = 0;
    rdValid = 1; rdHit = 1; rdAddr = 32'h5F0;
    step(); rdValid = 0; rdHit = 0;
    commit = 1; step(); commit = 0;
    run(4);

    // R7, R11: match on a speculative entry with different byte enables
    phase = "R7";
    push(32'h600, 32'h6666_0001, 4'h1);
    push(32'h604, 32'h6666_0002, 4'hF);
    push(32'h600, 32'h6666_0003, 4'h8);
    rdValid = 1; rdHit = 1; rdAddr = 32'h600;
    run(3);
    commit = 1;
    for (int i = 0; i < 30; i++) begin step(); if (lastGrant) break; end
    rdValid = 0; rdHit = 0; commit = 0;
    run(3);

    // R7: match released by flush
    phase = "R7f";
    push(32'h700, 32'h7777_0001, 4'hF);
    rdValid = 1; rdHit = 1; rdAddr = 32'h700;
    run(2);
    flush = 1; step(); flush = 0;
    step(); rdValid = 0; rdHit = 0;

    // R8: miss read waits for empty
    phase = "R8";
    push(32'h800, 32'h8888_0001, 4'hF);
    push(32'h804, 32'h8888_0002, 4'hF);
    rdValid = 1; rdHit = 0; rdAddr = 32'h900;
    run(2);
    commit = 1;
    for (int i = 0; i < 30; i++) begin step(); if (lastGrant) break; end
    rdValid = 0; commit = 0;
    run(2);

    // mixed traffic over colliding addresses
    phase = "R9mix";
    for (int i = 0; i < 3000; i++) begin
      if (!rdValid) begin
        rdValid = ($urandom_range(0, 3) == 0);
        rdHit   = ($urandom_range(0, 3) != 0);
        rdAddr  = 32'h10 + 32'($urandom_range(0, 3));
      end
      enqValid = ($urandom_range(0, 1) == 1);
      enqAddr  = 32'h10 + 32'($urandom_range(0, 3));
      enqData  = $urandom;
      enqBe    = 4'($urandom_range(1, 15));
      commit   = ($urandom_range(0, 2) != 0);
      flush    = ($urandom_range(0, 15) == 0);
      step();
      if (lastGrant) rdValid = 0;
    end
    idleIn();
    commit = 1; run(12); commit = 0;
    run(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule